// File: doc/BRIEF.md
# Card Punch Transfer Controller

This block is the host-side sequencer that moves one card image of BCD characters from memory into the input buffer of a card punch. Software starts it with a record base address. The controller waits until the punch reports that its buffer can take data. It then raises its data gate and lets the punch release the first character with a sync pulse. The punch may delay that sync while it finishes a row already under way. For each sync the controller reads the next character from ascending memory addresses and drives it onto seven data lines. It then paces the transfer and, for every character but the last, sends a sample pulse that asks the punch for the next sync.

Before each character goes out, the controller checks it for odd parity. A failed check sets a sticky error flag, and that flag withholds the write-check-OK level the punch needs before it may feed and punch the card. A disconnect from the punch ends the transfer. A reset request drives the manual-reset line and returns every latch to idle, but the error flag is kept. Only the hardware reset clears it.

State machine: `ST_IDLE` goes to `ST_ARM` on start. `ST_ARM` goes to `ST_SYNC_WAIT` when the buffer is ready. `ST_SYNC_WAIT` goes to `ST_FETCH` on a sync rising edge. `ST_FETCH` always goes to `ST_LOAD`. `ST_LOAD` goes to `ST_PACE`, or to `ST_DRAIN` after the last character. `ST_PACE` goes to `ST_STROBE` when the pace timer expires. `ST_STROBE` goes back to `ST_SYNC_WAIT` when the pulse timer expires. `ST_DRAIN` holds until a disconnect arrives. Every state except `ST_IDLE` goes to `ST_IDLE` on a disconnect or a reset request.

Top module: `punch_xfer_ctrl`

## Requirements
- R1: After the hardware reset, gate_o, sample_o, mem_rd_o and mreset_o are 0, data_o is 0 and wchk_ok_o is 1.
- R2: A start pulse in idle arms the controller. gate_o stays 0 until buf_rdy_i is seen high, and rises one cycle after that.
- R3: While gate_o is high and no sync edge has arrived, no memory read occurs and data_o does not change, however long the wait lasts.
- R4: The k-th sync edge of a card (k = 0..CHARS-1) reads address base+k modulo 2^AW. Two cycles after the edge is registered, data_o carries that character, and it holds its value until the next sync. Bit order is data_o[6]=C (check), [5]=A, [4]=B, [3]=8, [2]=4, [1]=2, [0]=1.
- R5: After characters 0..CHARS-2, sample_o pulses high for exactly PULSE_CYC cycles. No sample pulse follows the last character, so a card produces CHARS-1 pulses.
- R6: sample_o rises exactly PACE_CYC cycles after data_o takes a new character.
- R7: A character whose seven bits hold an even number of ones drops wchk_ok_o in the cycle it is driven. wchk_ok_o then stays 0 through later characters, later cards and reset requests.
- R8: A disconnect in any active state drops gate_o on the next cycle and returns the controller to idle, so later sync pulses cause no reads. After the last character, gate_o stays high until the disconnect.
- R9: A reset request drives mreset_o high one cycle later for as long as the request is held. It aborts any transfer, clearing gate_o and data_o, and leaves wchk_ok_o unchanged.
- R10: A start pulse during a transfer is ignored, and the addresses continue from the original base.
- R11: A sync held high for several cycles releases exactly one character, because only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset (also clears error flag) |
| start_i | input | 1 | Host request to punch one record |
| base_addr_i | input | AW | Record base address, taken with start_i |
| buf_rdy_i | input | 1 | Punch buffer can accept a card |
| psync_i | input | 1 | Punch sync, rising edge releases one character |
| disc_i | input | 1 | Punch disconnect, ends the transfer |
| rst_req_i | input | 1 | Manual / power reset request |
| mem_rd_o | output | 1 | Memory read strobe, data returns next cycle |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 7 | Memory read data (C,A,B,8,4,2,1) |
| gate_o | output | 1 | Data gate to the punch |
| sample_o | output | 1 | Per-character sample request |
| data_o | output | 7 | Character driven to the punch |
| wchk_ok_o | output | 1 | No write error seen, punching allowed |
| mreset_o | output | 1 | Manual-reset level to the punch |

## Verification
The hardest case to reach is a parity failure partway through a card, followed by a reset request that must clear everything except that failure. The bench memory derives every character from its address with correct odd parity, except one chosen address whose check bit is flipped. A full card is then sent over a base that puts the bad character near the middle. The bench watches wchk_ok_o stay low through the rest of that card, through a reset request that aborts a later transfer, and until the hardware reset. A second hard case is the row-in-progress delay. The bench holds the gate open with no sync for several cycles and confirms that nothing moves in that time.

// File: rtl/punch_xfer_pkg.sv
package punch_xfer_pkg;

    localparam int CHAR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SYNC_WAIT,
        ST_FETCH,
        ST_LOAD,
        ST_PACE,
        ST_STROBE,
        ST_DRAIN
    } pst_e;

    function automatic logic char_parity_ok(input logic [CHAR_W-1:0] c);
        return ^c;
    endfunction

endpackage

// File: rtl/punch_cycle_timer.sv
module punch_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/punch_char_path.sv
module punch_char_path
    import punch_xfer_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CHARS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [AW-1:0]     base_i,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [CHAR_W-1:0] mem_data_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              last_o,
    output logic              err_o
);
    localparam int CNT_W = $clog2(CHARS + 1);

    logic [AW-1:0]     base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CHAR_W-1:0] data_q;
    logic              err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (clear_i) begin
            base_q <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (arm_i) begin
            base_q <= base_i;
            cnt_q  <= '0;
        end else if (load_i) begin
            data_q <= mem_data_i;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Error latch: only the hardware reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (load_i && !clear_i && !char_parity_ok(mem_data_i)) begin
            err_q <= 1'b1;
        end
    end

    assign mem_addr_o = base_q + AW'(cnt_q);
    assign data_o     = data_q;
    assign last_o     = (cnt_q == CNT_W'(CHARS - 1));
    assign err_o      = err_q;
endmodule

// File: rtl/punch_seq_fsm.sv
module punch_seq_fsm
    import punch_xfer_pkg::*;
#(
    parameter int PACE_CYC  = 16,
    parameter int PULSE_CYC = 4,
    parameter int TW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          buf_rdy_i,
    input  logic          psync_i,
    input  logic          disc_i,
    input  logic          rst_req_i,
    input  logic          last_i,
    input  logic          tmr_exp_i,
    output logic          gate_o,
    output logic          sample_o,
    output logic          mem_rd_o,
    output logic          load_char_o,
    output logic          arm_o,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o
);
    pst_e state_q, state_d;
    logic sync_prev_q;
    logic sync_rise;

    assign sync_rise = psync_i && !sync_prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            sync_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            sync_prev_q <= psync_i;
        end
    end

    // Next state and timer loads
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_ARM;
            ST_ARM:       if (buf_rdy_i) state_d = ST_SYNC_WAIT;
            ST_SYNC_WAIT: if (sync_rise) state_d = ST_FETCH;
            ST_FETCH:     state_d = ST_LOAD;
            ST_LOAD: begin
                if (last_i) begin
                    state_d = ST_DRAIN;
                end else begin
                    state_d    = ST_PACE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(PACE_CYC - 1);
                end
            end
            ST_PACE: begin
                if (tmr_exp_i) begin
                    state_d    = ST_STROBE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(PULSE_CYC - 1);
                end
            end
            ST_STROBE:    if (tmr_exp_i) state_d = ST_SYNC_WAIT;
            ST_DRAIN:     state_d = ST_DRAIN;
            default:      state_d = ST_IDLE;
        endcase
        if ((state_q != ST_IDLE && disc_i) || rst_req_i) begin
            state_d = ST_IDLE;
        end
    end

    // Moore outputs
    always_comb begin
        gate_o      = 1'b0;
        sample_o    = 1'b0;
        mem_rd_o    = 1'b0;
        load_char_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARM: ;
            ST_SYNC_WAIT, ST_PACE, ST_DRAIN: gate_o = 1'b1;
            ST_FETCH: begin
                gate_o   = 1'b1;
                mem_rd_o = 1'b1;
            end
            ST_LOAD: begin
                gate_o      = 1'b1;
                load_char_o = 1'b1;
            end
            ST_STROBE: begin
                gate_o   = 1'b1;
                sample_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign arm_o = (state_q == ST_IDLE) && start_i && !rst_req_i;
endmodule

// File: rtl/punch_xfer_ctrl.sv
module punch_xfer_ctrl
    import punch_xfer_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CHARS     = 80,
    parameter int PACE_CYC  = 16,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     base_addr_i,
    input  logic              buf_rdy_i,
    input  logic              psync_i,
    input  logic              disc_i,
    input  logic              rst_req_i,
    output logic              mem_rd_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [CHAR_W-1:0] mem_data_i,
    output logic              gate_o,
    output logic              sample_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              wchk_ok_o,
    output logic              mreset_o
);
    localparam int TMAX = (PACE_CYC > PULSE_CYC) ? PACE_CYC : PULSE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    logic          load_char, arm, last, err, tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          mreset_q;

    punch_seq_fsm #(
        .PACE_CYC (PACE_CYC),
        .PULSE_CYC(PULSE_CYC),
        .TW       (TW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .buf_rdy_i  (buf_rdy_i),
        .psync_i    (psync_i),
        .disc_i     (disc_i),
        .rst_req_i  (rst_req_i),
        .last_i     (last),
        .tmr_exp_i  (tmr_exp),
        .gate_o     (gate_o),
        .sample_o   (sample_o),
        .mem_rd_o   (mem_rd_o),
        .load_char_o(load_char),
        .arm_o      (arm),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val)
    );

    punch_cycle_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .val_i    (tmr_val),
        .expired_o(tmr_exp)
    );

    punch_char_path #(.AW(AW), .CHARS(CHARS)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .base_i    (base_addr_i),
        .clear_i   (rst_req_i),
        .load_i    (load_char),
        .mem_data_i(mem_data_i),
        .mem_addr_o(mem_addr_o),
        .data_o    (data_o),
        .last_o    (last),
        .err_o     (err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mreset_q <= 1'b0;
        else        mreset_q <= rst_req_i;
    end

    assign mreset_o  = mreset_q;
    assign wchk_ok_o = !err;
endmodule

// File: rtl/punch_xfer_ctrl_chk.sv
module punch_xfer_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic buf_rdy_i,
    input logic disc_i,
    input logic rst_req_i,
    input logic mem_rd_o,
    input logic gate_o,
    input logic sample_o,
    input logic wchk_ok_o,
    input logic mreset_o
);
    a_r2_gate_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(buf_rdy_i));

    a_r3_read_under_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> gate_o);

    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    a_r5_sample_under_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (gate_o && !mem_rd_o));

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wchk_ok_o |=> !wchk_ok_o);

    a_r8_disc_drops_gate: assert property (@(posedge clk) disable iff (!rst_n)
        disc_i |=> !gate_o);

    a_r9_mreset_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> (mreset_o && !gate_o && !sample_o));
endmodule

bind punch_xfer_ctrl punch_xfer_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .buf_rdy_i(buf_rdy_i),
    .disc_i   (disc_i),
    .rst_req_i(rst_req_i),
    .mem_rd_o (mem_rd_o),
    .gate_o   (gate_o),
    .sample_o (sample_o),
    .wchk_ok_o(wchk_ok_o),
    .mreset_o (mreset_o)
);

// File: tb/punch_xfer_ctrl_bench.sv
module punch_xfer_ctrl_bench;
    localparam int AW    = 8;
    localparam int CHARS = 80;
    localparam int PACE  = 6;
    localparam int PULSE = 3;
    localparam int AMOD  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          buf_rdy_i = 1'b0;
    logic          psync_i = 1'b0;
    logic          disc_i = 1'b0;
    logic          rst_req_i = 1'b0;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [6:0]    mem_q = '0;
    logic          gate_o, sample_o, wchk_ok_o, mreset_o;
    logic [6:0]    data_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  rd_cnt = 0;
    int  samp_rises = 0;
    logic samp_prev = 1'b0;
    bit  exp_err = 1'b0;
    bit  bad_en = 1'b0;
    int  bad_addr = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    punch_xfer_ctrl #(
        .AW(AW), .CHARS(CHARS), .PACE_CYC(PACE), .PULSE_CYC(PULSE)
    ) u_punch_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .buf_rdy_i(buf_rdy_i), .psync_i(psync_i), .disc_i(disc_i),
        .rst_req_i(rst_req_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_q), .gate_o(gate_o), .sample_o(sample_o),
        .data_o(data_o), .wchk_ok_o(wchk_ok_o), .mreset_o(mreset_o)
    );

    function automatic logic [6:0] good_char(input int a);
        logic [5:0] lo;
        lo = 6'((a * 7 + 3) & 63);
        return {~^lo, lo};
    endfunction

    function automatic logic [6:0] bad_char(input int a);
        logic [6:0] g;
        g = good_char(a);
        return {~g[6], g[5:0]};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_q  <= (bad_en && int'(mem_addr_o) == bad_addr) ?
                      bad_char(int'(mem_addr_o)) : good_char(int'(mem_addr_o));
            rd_cnt <= rd_cnt + 1;
        end
        samp_prev <= sample_o;
        if (sample_o && !samp_prev) samp_rises <= samp_rises + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic open_card(input int base);
        int r0;
        logic [6:0] d0;
        base_addr_i = AW'(base);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(gate_o == 1'b0, "R2 gate before ready", gate_o, 0);
        buf_rdy_i = 1'b1;
        @(negedge clk);
        buf_rdy_i = 1'b0;
        chk(gate_o == 1'b1, "R2 gate after ready", gate_o, 1);
        // row in progress: no sync yet
        r0 = rd_cnt;
        d0 = data_o;
        repeat (8) @(negedge clk);
        chk(rd_cnt == r0, "R3 no read without sync", rd_cnt, r0);
        chk(data_o == d0, "R3 data still", data_o, d0);
    endtask

    task automatic send_char(input int base, input int k, input bit bad);
        int a, r0, s0, n, w;
        logic [6:0] e;
        a = (base + k) % AMOD;
        e = bad ? bad_char(a) : good_char(a);
        if (bad) exp_err = 1'b1;
        r0 = rd_cnt;
        s0 = samp_rises;
        psync_i = 1'b1;
        repeat (3) @(negedge clk);
        psync_i = 1'b0;
        chk(data_o == e, "R4 char value", data_o, e);
        chk(rd_cnt == r0 + 1, "R11 one read per sync", rd_cnt, r0 + 1);
        chk(wchk_ok_o == !exp_err, "R7 write check", wchk_ok_o, !exp_err);
        if (k < CHARS - 1) begin
            n = 0;
            while (!sample_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == PACE, "R6 pace to sample", n, PACE);
            w = 0;
            while (sample_o && w < 100) begin
                @(negedge clk);
                w++;
            end
            chk(w == PULSE, "R5 sample width", w, PULSE);
        end else begin
            repeat (PACE + PULSE + 4) @(negedge clk);
            chk(samp_rises == s0, "R5 no sample after last", samp_rises, s0);
            chk(gate_o == 1'b1, "R8 gate held in drain", gate_o, 1);
        end
        repeat (2) @(negedge clk);
        chk(data_o == e, "R4 data held", data_o, e);
    endtask

    task automatic close_card();
        int r0;
        disc_i = 1'b1;
        @(negedge clk);
        disc_i = 1'b0;
        chk(gate_o == 1'b0, "R8 gate drops on disconnect", gate_o, 0);
        r0 = rd_cnt;
        psync_i = 1'b1;
        repeat (3) @(negedge clk);
        psync_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_cnt == r0, "R8 idle ignores sync", rd_cnt, r0);
    endtask

    task automatic full_card(input int base, input int bad_k, input int ign_at);
        int s0;
        s0 = samp_rises;
        open_card(base);
        for (int k = 0; k < CHARS; k++) begin
            send_char(base, k, k == bad_k);
            if (k == ign_at) begin
                base_addr_i = AW'(base ^ 8'h5A);
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(gate_o == 1'b1, "R10 start ignored while busy", gate_o, 1);
            end
        end
        chk(samp_rises - s0 == CHARS - 1, "R5 pulses per card", samp_rises - s0, CHARS - 1);
        close_card();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(gate_o == 0 && sample_o == 0 && mem_rd_o == 0, "R1 outputs in reset",
            {gate_o, sample_o, mem_rd_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(data_o == 0, "R1 data after reset", data_o, 0);
        chk(wchk_ok_o == 1, "R1 write check after reset", wchk_ok_o, 1);
        chk(mreset_o == 0, "R1 manual reset idle", mreset_o, 0);

        full_card(0, -1, -1);
        full_card(200, -1, 10);          // R4 wrap past top, R10 start ignored

        open_card(50);                   // R8 early disconnect
        for (int k = 0; k < 5; k++) send_char(50, k, 1'b0);
        close_card();

        bad_en = 1'b1;
        bad_addr = 30 + 37;
        full_card(30, 37, -1);           // R7 bad parity mid card
        bad_en = 1'b0;

        // R9 reset request mid transfer
        open_card(90);
        for (int k = 0; k < 3; k++) send_char(90, k, 1'b0);
        rst_req_i = 1'b1;
        @(negedge clk);
        chk(mreset_o == 1, "R9 manual reset raised", mreset_o, 1);
        chk(gate_o == 0, "R9 gate cleared", gate_o, 0);
        chk(data_o == 0, "R9 data cleared", data_o, 0);
        chk(wchk_ok_o == 0, "R9 error kept", wchk_ok_o, 0);
        rst_req_i = 1'b0;
        @(negedge clk);
        chk(mreset_o == 0, "R9 manual reset released", mreset_o, 0);
        chk(wchk_ok_o == 0, "R7 error survives request", wchk_ok_o, 0);

        // hardware reset clears the error
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_err = 1'b0;
        @(negedge clk);
        chk(wchk_ok_o == 1, "R1 error cleared by reset", wchk_ok_o, 1);
        full_card(120, -1, -1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule